// File: doc/BRIEF.md
# I2C Controller Interrupt Event Unit

This block gathers the interrupt causes of a multimaster I2C controller into one status register and raises a single interrupt request line. Its inputs come from two places. The bus engine supplies start and stop strobes, address-match strobes, underflow and overrun strobes, the mode levels, FIFO fill levels and the remaining byte count. The host side supplies its TX data writes and RX data reads.

Each cause latches into a fixed bit of the status register, whether or not its interrupt is enabled. Software clears a cause by writing 1 to its bit. The interrupt line is high while any latched cause has its enable bit set. The slave-address cause has its own clear rule, which depends on its enable bit.

The unit also guards the host data path. A TX write into a full FIFO is dropped. An RX read from an empty FIFO leaves the returned data at its last value. Both cases raise the access-error cause.

Top module: `i2c_irq_unit`

## Requirements
- R1: After reset, stat_o, ien_o, irq_o and rd_data_o are all zero.
- R2: Cause bit positions are: access error 7, bus free 8, slave addressed 9, TX underflow 10, RX overrun 11, RX drain 13, TX drain 14. A write to ien_o keeps only these bits, so writing 16'hFFFF reads back 16'h6F80. All other bits of stat_o stay 0.
- R3: tx_wr_i with tx_full_i high, or rx_rd_i with rx_empty_i high, sets bit 7 at the next clock edge. In that case tx_push_o or rx_pop_o stays low; otherwise it follows the access in the same cycle.
- R4: A non-empty read loads rx_head_i into rd_data_o at the clock edge. A read while empty leaves rd_data_o unchanged.
- R5: stop_det_i sets bit 8. Single-cycle tx_und_i and rx_ovr_i pulses set bits 10 and 11.
- R6: An own_match_i, alt_match_i or gcall_i pulse sets bit 9 only while sccb_mode_i is 0.
- R7: Bit 13 sets on stop_det_i while transmit_i is 0 and rx_level_i < rx_thr_i + 1.
- R8: Bit 14 sets in any cycle where master_i and transmit_i are 1, tx_level_i < tx_thr_i + 1 and xfer_left_i < tx_thr_i + 1.
- R9: With ack_we_i high, a 1 in ack_data_i clears the matching cause bit. A 0 leaves it unchanged.
- R10: A cause that occurs in the same cycle as its write-1 clear leaves the bit set.
- R11: While ien_o[9] is 1, bit 9 clears only by write-1, and start or stop has no effect on it. While ien_o[9] is 0, write-1 has no effect on bit 9, and a start_det_i or stop_det_i clears it.
- R12: irq_o is high exactly when some bit of stat_o & ien_o is 1. Causes latch even when their enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_det_i | input | 1 | Start condition strobe |
| stop_det_i | input | 1 | Stop condition strobe |
| own_match_i | input | 1 | Own address match strobe |
| alt_match_i | input | 1 | Alternate own address match strobe |
| gcall_i | input | 1 | General call match strobe |
| sccb_mode_i | input | 1 | Camera-bus mode, which disables slave-address detection |
| tx_und_i | input | 1 | TX underflow strobe |
| rx_ovr_i | input | 1 | RX overrun strobe |
| master_i | input | 1 | Controller is bus master |
| transmit_i | input | 1 | Controller is transmitter |
| tx_level_i | input | LVL_W | TX FIFO fill level |
| rx_level_i | input | LVL_W | RX FIFO fill level |
| xfer_left_i | input | CNT_W | Bytes still to transfer |
| tx_thr_i | input | THR_W | TX threshold field |
| rx_thr_i | input | THR_W | RX threshold field |
| tx_wr_i | input | 1 | Host write to TX data |
| tx_full_i | input | 1 | TX FIFO full |
| rx_rd_i | input | 1 | Host read of RX data |
| rx_empty_i | input | 1 | RX FIFO empty |
| rx_head_i | input | DATA_W | Entry at the RX FIFO head |
| tx_push_o | output | 1 | Accepted TX push |
| rx_pop_o | output | 1 | Accepted RX pop |
| rd_data_o | output | DATA_W | Data returned to the host read |
| ack_we_i | input | 1 | Write strobe for the status acknowledge |
| ack_data_i | input | REG_W | Write-1-to-clear data |
| ien_we_i | input | 1 | Enable register write strobe |
| ien_data_i | input | REG_W | Enable register write data |
| stat_o | output | REG_W | Status register |
| ien_o | output | REG_W | Enable register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the slave-address bit with its enable bit low. There, a write-1 must fail to clear it and a later start must clear it. The stimulus then sets the enable and shows that a start and a stop both leave the bit set. The same-cycle race between a cause strobe and its write-1 clear is produced by driving both in one cycle. The threshold compares are probed with levels of exactly the threshold, one above it, and a transfer count that fails while the level passes.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  localparam int REG_W     = 16;
  localparam int THR_W     = 6;
  localparam int N_EVT     = 7;
  localparam int B_ACCERR  = 7;
  localparam int B_BUSFREE = 8;
  localparam int B_SLVADDR = 9;
  localparam int B_TXUND   = 10;
  localparam int B_RXOVR   = 11;
  localparam int B_RXDRAIN = 13;
  localparam int B_TXDRAIN = 14;
  localparam logic [REG_W-1:0] IMPL_MASK = 16'h6F80;

  // event index -> status bit position
  function automatic int evt_pos(input int idx);
    case (idx)
      0:       return B_ACCERR;
      1:       return B_BUSFREE;
      2:       return B_SLVADDR;
      3:       return B_TXUND;
      4:       return B_RXOVR;
      5:       return B_RXDRAIN;
      default: return B_TXDRAIN;
    endcase
  endfunction
endpackage

// File: rtl/i2c_irq_host_acc.sv
module i2c_irq_host_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_wr_i,
  input  logic              tx_full_i,
  input  logic              rx_rd_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic              tx_push_o,
  output logic              rx_pop_o,
  output logic              acc_err_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] rd_q;

  assign tx_push_o = tx_wr_i & ~tx_full_i;
  assign rx_pop_o  = rx_rd_i & ~rx_empty_i;
  assign acc_err_o = (tx_wr_i & tx_full_i) | (rx_rd_i & rx_empty_i);

  // empty read keeps last value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (rx_pop_o) rd_q <= rx_head_i;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/i2c_irq_cond.sv
module i2c_irq_cond
  import i2c_irq_pkg::*;
#(
  parameter int LVL_W = 7,
  parameter int CNT_W = 16
) (
  input  logic             start_det_i,
  input  logic             stop_det_i,
  input  logic             own_match_i,
  input  logic             alt_match_i,
  input  logic             gcall_i,
  input  logic             sccb_mode_i,
  input  logic             tx_und_i,
  input  logic             rx_ovr_i,
  input  logic             master_i,
  input  logic             transmit_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] xfer_left_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic             acc_err_i,
  output logic [N_EVT-1:0] set_o,
  output logic             bus_cond_o
);
  localparam int W0    = (LVL_W > CNT_W) ? LVL_W : CNT_W;
  localparam int CMP_W = ((W0 > THR_W) ? W0 : THR_W) + 1;

  logic [CMP_W-1:0] tx_lvl_x, rx_lvl_x, left_x, tx_lim, rx_lim;
  logic             rx_low, tx_low, left_low;

  always_comb begin
    tx_lvl_x = CMP_W'(tx_level_i);
    rx_lvl_x = CMP_W'(rx_level_i);
    left_x   = CMP_W'(xfer_left_i);
    tx_lim   = CMP_W'(tx_thr_i) + CMP_W'(1);
    rx_lim   = CMP_W'(rx_thr_i) + CMP_W'(1);
    rx_low   = rx_lvl_x < rx_lim;
    tx_low   = tx_lvl_x < tx_lim;
    left_low = left_x < tx_lim;
  end

  always_comb begin
    set_o    = '0;
    set_o[0] = acc_err_i;
    set_o[1] = stop_det_i;
    set_o[2] = ~sccb_mode_i & (own_match_i | alt_match_i | gcall_i);
    set_o[3] = tx_und_i;
    set_o[4] = rx_ovr_i;
    set_o[5] = stop_det_i & ~transmit_i & rx_low;
    set_o[6] = master_i & transmit_i & tx_low & left_low;
  end

  assign bus_cond_o = start_det_i | stop_det_i;
endmodule

// File: rtl/i2c_irq_stat_bit.sv
module i2c_irq_stat_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= 1'b0;
    else if (set_i)  q <= 1'b1;
    else if (clr_i)  q <= 1'b0;
  end
  assign q_o = q;
endmodule

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 7,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              own_match_i,
  input  logic              alt_match_i,
  input  logic              gcall_i,
  input  logic              sccb_mode_i,
  input  logic              tx_und_i,
  input  logic              rx_ovr_i,
  input  logic              master_i,
  input  logic              transmit_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [CNT_W-1:0]  xfer_left_i,
  input  logic [THR_W-1:0]  tx_thr_i,
  input  logic [THR_W-1:0]  rx_thr_i,
  input  logic              tx_wr_i,
  input  logic              tx_full_i,
  input  logic              rx_rd_i,
  input  logic              rx_empty_i,
  input  logic [DATA_W-1:0] rx_head_i,
  output logic              tx_push_o,
  output logic              rx_pop_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ack_we_i,
  input  logic [REG_W-1:0]  ack_data_i,
  input  logic              ien_we_i,
  input  logic [REG_W-1:0]  ien_data_i,
  output logic [REG_W-1:0]  stat_o,
  output logic [REG_W-1:0]  ien_o,
  output logic              irq_o
);
  logic             acc_err;
  logic [N_EVT-1:0] evt_set, evt_q;
  logic             bus_cond;
  logic [REG_W-1:0] ien_q;

  i2c_irq_host_acc #(.DATA_W(DATA_W)) u_host (
    .clk_i, .rst_ni, .tx_wr_i, .tx_full_i, .rx_rd_i, .rx_empty_i, .rx_head_i,
    .tx_push_o, .rx_pop_o, .acc_err_o(acc_err), .rd_data_o
  );

  i2c_irq_cond #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_cond (
    .start_det_i, .stop_det_i, .own_match_i, .alt_match_i, .gcall_i,
    .sccb_mode_i, .tx_und_i, .rx_ovr_i, .master_i, .transmit_i,
    .tx_level_i, .rx_level_i, .xfer_left_i, .tx_thr_i, .rx_thr_i,
    .acc_err_i(acc_err), .set_o(evt_set), .bus_cond_o(bus_cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ien_q <= '0;
    else if (ien_we_i) ien_q <= ien_data_i & IMPL_MASK;
  end

  for (genvar g = 0; g < N_EVT; g++) begin : g_stat
    localparam int P = evt_pos(g);
    logic clr;
    if (P == B_SLVADDR) begin : g_slv
      // enabled: write-1 only; disabled: next start/stop
      assign clr = ien_q[P] ? (ack_we_i & ack_data_i[P]) : bus_cond;
    end else begin : g_std
      assign clr = ack_we_i & ack_data_i[P];
    end
    i2c_irq_stat_bit u_bit (
      .clk_i, .rst_ni, .set_i(evt_set[g]), .clr_i(clr), .q_o(evt_q[g])
    );
  end

  always_comb begin
    stat_o = '0;
    for (int i = 0; i < N_EVT; i++) stat_o[evt_pos(i)] = evt_q[i];
  end

  assign ien_o = ien_q;
  assign irq_o = |(stat_o & ien_q);
endmodule

// File: rtl/i2c_irq_unit_chk.sv
module i2c_irq_unit_chk
  import i2c_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_det_i,
  input logic              stop_det_i,
  input logic              own_match_i,
  input logic              alt_match_i,
  input logic              gcall_i,
  input logic              sccb_mode_i,
  input logic              tx_und_i,
  input logic              tx_wr_i,
  input logic              tx_full_i,
  input logic              rx_rd_i,
  input logic              rx_empty_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ack_we_i,
  input logic [REG_W-1:0]  ack_data_i,
  input logic [REG_W-1:0]  stat_o,
  input logic [REG_W-1:0]  ien_o,
  input logic              irq_o
);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o & ~IMPL_MASK) == '0);

  a_r3_bad_tx_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i && tx_full_i |=> stat_o[B_ACCERR]);

  a_r4_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_i && rx_empty_i |=> $stable(rd_data_o));

  a_r5_stop_sets_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det_i |=> stat_o[B_BUSFREE]);

  a_r9_no_w1_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[B_TXUND] && !(ack_we_i && ack_data_i[B_TXUND]) |=> stat_o[B_TXUND]);

  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_und_i |=> stat_o[B_TXUND]);

  a_r11_enabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_o[B_SLVADDR] && stat_o[B_SLVADDR] && !(ack_we_i && ack_data_i[B_SLVADDR])
    |=> stat_o[B_SLVADDR]);

  a_r11_disabled_auto: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_o[B_SLVADDR] && stat_o[B_SLVADDR] && (start_det_i || stop_det_i) &&
    !(!sccb_mode_i && (own_match_i || alt_match_i || gcall_i))
    |=> !stat_o[B_SLVADDR]);

  a_r12_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_o == '0 |-> !irq_o);
endmodule

bind i2c_irq_unit i2c_irq_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_i2c_irq_unit.sv
module test_i2c_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_det = 0, stop_det = 0, own_m = 0, alt_m = 0, gc = 0, sccb = 0;
  logic        und = 0, ovr = 0, mst = 0, tx = 0;
  logic [6:0]  txl = 7'h7F, rxl = 7'h7F;
  logic [15:0] left = 16'hFFFF;
  logic [5:0]  tthr = 0, rthr = 0;
  logic        tx_wr = 0, tx_full = 0, rx_rd = 0, rx_empty = 0;
  logic [7:0]  rx_head = 0;
  logic        tx_push, rx_pop, irq;
  logic [7:0]  rd_data;
  logic        ack_we = 0, ien_we = 0;
  logic [15:0] ack_data = 0, ien_data = 0, stat, ien;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  i2c_irq_unit i_i2c_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_det_i(start_det), .stop_det_i(stop_det),
    .own_match_i(own_m), .alt_match_i(alt_m), .gcall_i(gc), .sccb_mode_i(sccb),
    .tx_und_i(und), .rx_ovr_i(ovr), .master_i(mst), .transmit_i(tx),
    .tx_level_i(txl), .rx_level_i(rxl), .xfer_left_i(left),
    .tx_thr_i(tthr), .rx_thr_i(rthr), .tx_wr_i(tx_wr), .tx_full_i(tx_full),
    .rx_rd_i(rx_rd), .rx_empty_i(rx_empty), .rx_head_i(rx_head),
    .tx_push_o(tx_push), .rx_pop_o(rx_pop), .rd_data_o(rd_data),
    .ack_we_i(ack_we), .ack_data_i(ack_data), .ien_we_i(ien_we),
    .ien_data_i(ien_data), .stat_o(stat), .ien_o(ien), .irq_o(irq)
  );

  typedef struct packed {
    logic stop, start, own, alt, gcl, sc, un, ov, ms, tr;
    logic [6:0] tl, rl; logic [15:0] lf; logic [5:0] tt, rt; logic [15:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1,0,0,0,0,0,0,0,0,0, 7'h7F, 7'd10, 16'hFFFF, 6'd0, 6'd3, 16'h0100}, // R7 above
    '{1,0,0,0,0,0,0,0,0,0, 7'h7F, 7'd4,  16'hFFFF, 6'd0, 6'd3, 16'h0100}, // R7 thr+1
    '{1,0,0,0,0,0,0,0,0,0, 7'h7F, 7'd3,  16'hFFFF, 6'd0, 6'd3, 16'h2100}, // R7 at thr
    '{1,0,0,0,0,0,0,0,0,1, 7'h7F, 7'd0,  16'hFFFF, 6'd0, 6'd3, 16'h0100}, // R7 transmitter
    '{0,0,1,0,0,0,0,0,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0200}, // R6 own
    '{0,0,0,0,1,1,0,0,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0000}, // R6 sccb
    '{0,0,0,1,0,0,0,0,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0200}, // R6 alt
    '{0,0,0,0,1,0,0,0,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0200}, // R6 gcall
    '{0,0,0,0,0,0,1,1,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0C00}, // R5 und+ovr
    '{0,0,0,0,0,0,0,0,1,1, 7'd2,  7'h7F, 16'd2,    6'd2, 6'd0, 16'h4000}, // R8 at thr
    '{0,0,0,0,0,0,0,0,1,1, 7'd3,  7'h7F, 16'd0,    6'd2, 6'd0, 16'h0000}, // R8 level high
    '{0,0,0,0,0,0,0,0,1,1, 7'd0,  7'h7F, 16'd3,    6'd2, 6'd0, 16'h0000}, // R8 count high
    '{0,0,0,0,0,0,0,0,0,1, 7'd0,  7'h7F, 16'd0,    6'd2, 6'd0, 16'h0000}, // R8 slave
    '{1,0,0,0,0,0,0,0,1,0, 7'd0,  7'd0,  16'd0,    6'd5, 6'd0, 16'h2100}, // R7/R8 master rx
    '{0,1,0,0,0,0,0,0,0,0, 7'h7F, 7'h7F, 16'hFFFF, 6'd0, 6'd0, 16'h0000}  // R5 start only
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic ack(input logic [15:0] d);
    ack_we = 1; ack_data = d; cyc(); ack_we = 0; ack_data = 0;
  endtask

  task automatic set_ien(input logic [15:0] d);
    ien_we = 1; ien_data = d; cyc(); ien_we = 0;
  endtask

  task automatic pulse_und(); und = 1; cyc(); und = 0; endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    repeat (3) cyc();
    chk("R1 stat", stat, 0); chk("R1 ien", ien, 0);
    chk("R1 irq", irq, 0);   chk("R1 rd_data", rd_data, 0);
    rst_n = 1; cyc();

    set_ien(16'hFFFF);
    chk("R2 ien mask", ien, 16'h6F80);

    for (int i = 0; i < NV; i++) begin
      stop_det = VEC[i].stop; start_det = VEC[i].start; own_m = VEC[i].own;
      alt_m = VEC[i].alt; gc = VEC[i].gcl; sccb = VEC[i].sc; und = VEC[i].un;
      ovr = VEC[i].ov; mst = VEC[i].ms; tx = VEC[i].tr; txl = VEC[i].tl;
      rxl = VEC[i].rl; left = VEC[i].lf; tthr = VEC[i].tt; rthr = VEC[i].rt;
      cyc();
      {stop_det, start_det, own_m, alt_m, gc, sccb, und, ovr} = '0;
      mst = 0; tx = 0; txl = 7'h7F; rxl = 7'h7F; left = 16'hFFFF; tthr = 0; rthr = 0;
      chk($sformatf("R2/R5-R8 vector %0d", i), stat, VEC[i].exp);
      ack(16'hFFFF);
      chk($sformatf("R9 clear after vector %0d", i), stat, 0);
    end

    chk("R12 idle irq", irq, 0);
    pulse_und();
    chk("R12 irq on", irq, 1);
    set_ien(16'h0000);
    chk("R12 irq masked", irq, 0);
    chk("R12 latched while disabled", stat, 16'h0400);
    ack(16'hFBFF);
    chk("R9 zero write keeps", stat, 16'h0400);
    und = 1; ack_we = 1; ack_data = 16'h0400; cyc();
    und = 0; ack_we = 0; ack_data = 0;
    chk("R10 set beats clear", stat, 16'h0400);
    ack(16'h0400);
    chk("R9 clear", stat, 0);

    own_m = 1; cyc(); own_m = 0;
    chk("R11 set disabled", stat, 16'h0200);
    ack(16'h0200);
    chk("R11 w1c ignored when disabled", stat, 16'h0200);
    start_det = 1; cyc(); start_det = 0;
    chk("R11 start clears", stat, 0);
    own_m = 1; cyc(); own_m = 0;
    set_ien(16'h0200);
    start_det = 1; cyc(); start_det = 0;
    chk("R11 start ignored when enabled", stat, 16'h0200);
    stop_det = 1; cyc(); stop_det = 0;
    chk("R11 stop ignored when enabled", stat, 16'h0300);
    chk("R12 irq slave", irq, 1);
    ack(16'h0300);
    chk("R11 w1c when enabled", stat, 0);

    tx_wr = 1; #1 chk("R3 push ok", tx_push, 1);
    cyc(); tx_wr = 0;
    chk("R3 no error", stat, 0);
    tx_wr = 1; tx_full = 1; #1 chk("R3 push blocked", tx_push, 0);
    cyc(); tx_wr = 0; tx_full = 0;
    chk("R3 tx error", stat, 16'h0080);
    ack(16'h0080);
    rx_rd = 1; rx_head = 8'hA5; #1 chk("R3 pop ok", rx_pop, 1);
    cyc(); rx_rd = 0;
    chk("R4 read data", rd_data, 8'hA5);
    chk("R3 no rx error", stat, 0);
    rx_rd = 1; rx_empty = 1; rx_head = 8'h3C; #1 chk("R3 pop blocked", rx_pop, 0);
    cyc(); rx_rd = 0; rx_empty = 0;
    chk("R4 empty read holds", rd_data, 8'hA5);
    chk("R3 rx error", stat, 16'h0080);

    set_ien(16'hFFFF);
    rst_n = 0; #1;
    chk("R1 stat after reset", stat, 0);
    chk("R1 ien after reset", ien, 0);
    chk("R1 rd_data after reset", rd_data, 0);
    chk("R1 irq after reset", irq, 0);
    cyc();
    summary();
  end
endmodule